// File: doc/BRIEF.md
# Event-Trigger Prescaler with Sticky Flags

This block thins out trigger events on three channels. Channels 0 and 1 produce converter start-of-conversion requests. Channel 2 produces an interrupt request. Each channel counts its own event strobe. When the count reaches a programmed period, the channel emits a one-cycle pulse, clears its count in the same edge and raises a sticky status flag. Software or a neighbouring block clears the flag with a per-channel clear strobe. The current counts stay visible on an output bus.

Each channel has two period values. One is a 2-bit short period and the other is a 4-bit long period. One select bit chooses between them for both converter channels, and a second select bit chooses for the interrupt channel. A period of zero switches the channel's counter off.

The converter channels fire even while their flag is still set. The interrupt channel stalls when it is disabled or its flag is pending: its count climbs to the period and stays there. Once the channel is released, the next event fires it.

Each channel classifies itself every cycle from its live count and period into one of three states:

- OFF: the period is zero.
- COUNT: the next event still leaves the count below the period.
- LAST: the next event meets or passes the period.

The transitions are:

- count-up: COUNT to COUNT or LAST.
- fire: LAST back to COUNT with the count at zero.
- stall: LAST holding, with the count at the period.
- switch-off: any state to OFF when the period is written to zero.

Top module: `evtps_top`

## Requirements
- R1: In short mode, each event on a channel with a nonzero period and no pulse due raises that channel's 4-bit count field (channel c at count_o bits [4c+3:4c]) by exactly one. With no event, the count does not change.
- R2: When the selected period is zero, the channel never pulses and its count stays unchanged.
- R3: In short mode with period P of 1, 2 or 3 and the channel enabled and unblocked, the pulse appears in the cycle after the P-th, 2P-th, and later multiples of P events.
- R4: In the edge that produces a pulse, the channel's count returns to zero.
- R5: A converter channel (0 or 1) pulses only while its enable is 1. It pulses regardless of its flag. While disabled, its count climbs to the period and holds there.
- R6: While the interrupt channel (2) has enable 0 or its flag set, it does not pulse. Its count rises to the period and holds at that value.
- R7: With the long select set, the 4-bit period (1 to 15) is used, and the pulse follows every P-th event.
- R8: A pulse sets that channel's flag. The flag stays set until a clear strobe arrives. A clear in the same cycle as a pulse leaves the flag set.
- R9: A stalled interrupt channel, once re-enabled with its flag clear, pulses on the next event and clears its count.
- R10: Changing a period or a mode select does not alter the count. A count at or above a newly lowered period fires on the next enabled event.
- R11: A synchronous active-low reset sets every count, flag and pulse to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_i | input | 3 | Event strobe per channel (0,1 converter, 2 interrupt) |
| en_i | input | 3 | Pulse enable per channel |
| clr_i | input | 3 | Flag clear strobe per channel |
| prd_short_i | input | 6 | 2-bit short period per channel, channel c at [2c+1:2c] |
| prd_long_i | input | 12 | 4-bit long period per channel, channel c at [4c+3:4c] |
| long_conv_i | input | 1 | Selects long periods for channels 0 and 1 |
| long_irq_i | input | 1 | Selects long period for channel 2 |
| pulse_o | output | 3 | One-cycle output pulse per channel |
| flag_o | output | 3 | Sticky status flag per channel |
| count_o | output | 12 | Event count per channel, channel c at [4c+3:4c] |

## Verification
The assertions assume that every input is driven to a known level at every clock edge. They also assume reset is held low across the first edge, so that the reset property sees a defined antecedent.

The converter-pulse properties rely on a pulse being traceable to the previous cycle's event and enable. This holds because the bench changes strobes only at the falling edge and drops them again after each rising edge.

Period and mode changes are applied only between events, so each event is judged against one stable period.

// File: rtl/evtps_pkg.sv
package evtps_pkg;
    localparam int NCH    = 3;
    localparam int IRQ_CH = 2;

    typedef enum logic [1:0] {
        CH_OFF   = 2'd0,
        CH_COUNT = 2'd1,
        CH_LAST  = 2'd2
    } ch_state_t;
endpackage

// File: rtl/evtps_period_sel.sv
module evtps_period_sel #(
    parameter int SHORT_W = 2,
    parameter int LONG_W  = 4
) (
    input  logic [SHORT_W-1:0] short_prd,
    input  logic [LONG_W-1:0]  long_prd,
    input  logic               use_long,
    output logic [LONG_W-1:0]  eff_prd
);
    localparam int PAD_W = LONG_W - SHORT_W;

    always_comb begin
        if (use_long) eff_prd = long_prd;
        else          eff_prd = {{PAD_W{1'b0}}, short_prd};
    end
endmodule

// File: rtl/evtps_channel.sv
module evtps_channel
    import evtps_pkg::*;
#(
    parameter int CNT_W         = 4,
    parameter bit STALL_ON_FLAG = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt,
    input  logic             en,
    input  logic             clr,
    input  logic [CNT_W-1:0] period,
    output logic             pulse,
    output logic             flag,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             flag_q, flag_d;
    logic             pulse_q, fire;
    logic             blocked;
    logic [CNT_W:0]   cnt_inc;
    ch_state_t        cur_st;

    // classify the channel from its live count and period
    always_comb begin
        cnt_inc = {1'b0, cnt_q} + 1'b1;
        if (period == '0)                 cur_st = CH_OFF;
        else if (cnt_inc < {1'b0, period}) cur_st = CH_COUNT;
        else                              cur_st = CH_LAST;
    end

    // next-state actions
    always_comb begin
        blocked = !en || (STALL_ON_FLAG && flag_q);
        fire    = 1'b0;
        cnt_d   = cnt_q;
        unique case (cur_st)
            CH_OFF: begin
                cnt_d = cnt_q;
            end
            CH_COUNT: begin
                if (evt) cnt_d = cnt_inc[CNT_W-1:0];
            end
            CH_LAST: begin
                if (evt && !blocked) begin
                    fire  = 1'b1;
                    cnt_d = '0;
                end else if (evt && (cnt_q < period)) begin
                    cnt_d = cnt_inc[CNT_W-1:0];
                end
            end
            default: cnt_d = cnt_q;
        endcase
        if (fire)     flag_d = 1'b1;
        else if (clr) flag_d = 1'b0;
        else          flag_d = flag_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            flag_q  <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            cnt_q   <= cnt_d;
            flag_q  <= flag_d;
            pulse_q <= fire;
        end
    end

    assign pulse = pulse_q;
    assign flag  = flag_q;
    assign count = cnt_q;
endmodule

// File: rtl/evtps_top.sv
module evtps_top
    import evtps_pkg::*;
#(
    parameter int SHORT_W = 2,
    parameter int LONG_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NCH-1:0]          evt_i,
    input  logic [NCH-1:0]          en_i,
    input  logic [NCH-1:0]          clr_i,
    input  logic [NCH*SHORT_W-1:0]  prd_short_i,
    input  logic [NCH*LONG_W-1:0]   prd_long_i,
    input  logic                    long_conv_i,
    input  logic                    long_irq_i,
    output logic [NCH-1:0]          pulse_o,
    output logic [NCH-1:0]          flag_o,
    output logic [NCH*LONG_W-1:0]   count_o
);
    logic [NCH*LONG_W-1:0] eff_prd;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam bit IS_IRQ = (c == IRQ_CH);
        logic use_long;
        assign use_long = IS_IRQ ? long_irq_i : long_conv_i;

        evtps_period_sel #(.SHORT_W(SHORT_W), .LONG_W(LONG_W)) u_sel (
            .short_prd (prd_short_i[c*SHORT_W +: SHORT_W]),
            .long_prd  (prd_long_i[c*LONG_W +: LONG_W]),
            .use_long  (use_long),
            .eff_prd   (eff_prd[c*LONG_W +: LONG_W])
        );

        evtps_channel #(.CNT_W(LONG_W), .STALL_ON_FLAG(IS_IRQ)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .evt    (evt_i[c]),
            .en     (en_i[c]),
            .clr    (clr_i[c]),
            .period (eff_prd[c*LONG_W +: LONG_W]),
            .pulse  (pulse_o[c]),
            .flag   (flag_o[c]),
            .count  (count_o[c*LONG_W +: LONG_W])
        );
    end
endmodule

// File: rtl/evtps_checker.sv
module evtps_checker
    import evtps_pkg::*;
#(
    parameter int LONG_W = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NCH-1:0]        evt_i,
    input logic [NCH-1:0]        en_i,
    input logic [NCH-1:0]        clr_i,
    input logic [NCH-1:0]        pulse_o,
    input logic [NCH-1:0]        flag_o,
    input logic [NCH*LONG_W-1:0] count_o,
    input logic [NCH*LONG_W-1:0] eff_prd
);
    p_reset_clears_r11: assert property (@(posedge clk)
        !rst_n |=> (pulse_o == '0 && flag_o == '0 && count_o == '0));

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        p_idle_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
            !evt_i[c] |=> $stable(count_o[c*LONG_W +: LONG_W]));

        p_zero_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
            pulse_o[c] |-> $past(eff_prd[c*LONG_W +: LONG_W]) != '0);

        p_pulse_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
            pulse_o[c] |-> count_o[c*LONG_W +: LONG_W] == '0);

        p_flag_on_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
            pulse_o[c] |-> flag_o[c]);

        p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_o[c] && !clr_i[c]) |=> flag_o[c]);

        if (c == IRQ_CH) begin : g_irq
            p_irq_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
                pulse_o[c] |-> ($past(en_i[c]) && !$past(flag_o[c]) && $past(evt_i[c])));
        end else begin : g_conv
            p_conv_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
                pulse_o[c] |-> ($past(en_i[c]) && $past(evt_i[c])));
        end
    end
endmodule

bind evtps_top evtps_checker #(.LONG_W(LONG_W)) u_evtps_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_i   (evt_i),
    .en_i    (en_i),
    .clr_i   (clr_i),
    .pulse_o (pulse_o),
    .flag_o  (flag_o),
    .count_o (count_o),
    .eff_prd (eff_prd)
);

// File: tb/evtps_top_test.sv
`timescale 1ns/1ps
module evtps_top_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  evt_i, en_i, clr_i;
    logic [5:0]  prd_short_i;
    logic [11:0] prd_long_i;
    logic        long_conv_i, long_irq_i;
    logic [2:0]  pulse_o, flag_o;
    logic [11:0] count_o;

    int errs = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    evtps_top uut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .en_i(en_i), .clr_i(clr_i),
        .prd_short_i(prd_short_i), .prd_long_i(prd_long_i),
        .long_conv_i(long_conv_i), .long_irq_i(long_irq_i),
        .pulse_o(pulse_o), .flag_o(flag_o), .count_o(count_o)
    );

    function automatic int cnt_of(int c);
        return int'(count_o[c*4 +: 4]);
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick(logic [2:0] e, logic [2:0] c);
        @(negedge clk);
        evt_i = e;
        clr_i = c;
        @(posedge clk);
        #1;
        evt_i = '0;
        clr_i = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic set_prd(int ps, int pl);
        prd_short_i = {3{2'(ps)}};
        prd_long_i  = {3{4'(pl)}};
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        errs++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        evt_i = '0;
        en_i = '0;
        clr_i = '0;
        long_conv_i = 1'b0;
        long_irq_i = 1'b0;
        set_prd(0, 0);
        @(posedge clk);
        #1;
        // R11: reset state
        chk(pulse_o == 0 && flag_o == 0 && count_o == 0, "R11 reset", int'(count_o), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 R2 R3 R4 R8: short mode sweep over every period
        for (int p = 0; p < 4; p++) begin
            long_conv_i = 1'b0;
            long_irq_i = 1'b0;
            set_prd(p, 0);
            en_i = 3'b111;
            do_reset();
            for (int n = 1; n <= 8; n++) begin
                bit ep;
                int ec;
                ep = (p != 0) && (n % p == 0);
                ec = (p == 0) ? 0 : n % p;
                tick(3'b111, 3'b000);
                chk(pulse_o == (ep ? 3'b111 : 3'b000), (p == 0) ? "R2 pulse" : "R3 pulse",
                    int'(pulse_o), ep ? 7 : 0);
                for (int c = 0; c < 3; c++)
                    chk(cnt_of(c) == ec, (p == 0) ? "R2 count" : (ep ? "R4 count" : "R1 count"),
                        cnt_of(c), ec);
                chk(flag_o == (ep ? 3'b111 : 3'b000), "R8 flag set", int'(flag_o), ep ? 7 : 0);
                tick(3'b000, 3'b111);
                chk(flag_o == 0 && pulse_o == 0, "R8 flag clear", int'(flag_o), 0);
            end
        end

        // R7: long mode sweep over every period
        for (int p = 0; p < 16; p++) begin
            long_conv_i = 1'b1;
            long_irq_i = 1'b1;
            set_prd(0, p);
            en_i = 3'b111;
            do_reset();
            for (int n = 1; n <= ((p == 0) ? 3 : 2 * p + 1); n++) begin
                bit ep;
                int ec;
                ep = (p != 0) && (n % p == 0);
                ec = (p == 0) ? 0 : n % p;
                tick(3'b111, 3'b000);
                chk(pulse_o == (ep ? 3'b111 : 3'b000), "R7 pulse", int'(pulse_o), ep ? 7 : 0);
                chk(cnt_of(0) == ec && cnt_of(2) == ec, "R7 count", cnt_of(2), ec);
                tick(3'b000, 3'b111);
            end
        end

        // R5: converter channels gated by enable, not by flag
        long_conv_i = 1'b0;
        long_irq_i = 1'b0;
        set_prd(2, 0);
        en_i = 3'b100;
        do_reset();
        for (int n = 1; n <= 3; n++) begin
            tick(3'b011, 3'b000);
            chk(pulse_o == 3'b000, "R5 disabled no pulse", int'(pulse_o), 0);
            chk(cnt_of(0) == ((n < 2) ? n : 2), "R5 hold at period", cnt_of(0), (n < 2) ? n : 2);
        end
        en_i = 3'b111;
        tick(3'b001, 3'b000);
        chk(pulse_o == 3'b001 && cnt_of(0) == 0, "R5 enabled fires", int'(pulse_o), 1);
        tick(3'b001, 3'b000);
        chk(cnt_of(0) == 1 && flag_o[0], "R5 count with flag", cnt_of(0), 1);
        tick(3'b001, 3'b000);
        chk(pulse_o == 3'b001, "R5 fires while flag set", int'(pulse_o), 1);

        // R6 R9: interrupt channel stall and release
        set_prd(3, 0);
        en_i = 3'b011;
        do_reset();
        for (int n = 1; n <= 5; n++) begin
            tick(3'b100, 3'b000);
            chk(pulse_o == 0, "R6 disabled no pulse", int'(pulse_o), 0);
            chk(cnt_of(2) == ((n < 3) ? n : 3), "R6 hold at period", cnt_of(2), (n < 3) ? n : 3);
        end
        en_i = 3'b111;
        tick(3'b100, 3'b000);
        chk(pulse_o == 3'b100 && cnt_of(2) == 0, "R9 release fires", int'(pulse_o), 4);
        for (int n = 1; n <= 4; n++) begin
            tick(3'b100, 3'b000);
            chk(pulse_o == 0, "R6 flag blocks", int'(pulse_o), 0);
            chk(cnt_of(2) == ((n < 3) ? n : 3), "R6 flag hold", cnt_of(2), (n < 3) ? n : 3);
        end
        tick(3'b000, 3'b100);
        chk(flag_o[2] == 1'b0, "R8 clear", int'(flag_o), 0);
        tick(3'b100, 3'b100);
        chk(pulse_o == 3'b100, "R9 fires after clear", int'(pulse_o), 4);
        chk(flag_o[2] == 1'b1, "R8 set beats clear", int'(flag_o[2]), 1);

        // R10: period and mode changes keep the count
        long_conv_i = 1'b1;
        set_prd(3, 10);
        en_i = 3'b111;
        do_reset();
        for (int n = 1; n <= 6; n++) tick(3'b001, 3'b000);
        chk(cnt_of(0) == 6, "R10 long count", cnt_of(0), 6);
        set_prd(3, 4);
        tick(3'b000, 3'b000);
        chk(cnt_of(0) == 6 && pulse_o == 0, "R10 period change keeps count", cnt_of(0), 6);
        tick(3'b001, 3'b000);
        chk(pulse_o == 3'b001 && cnt_of(0) == 0, "R10 lowered period fires", int'(pulse_o), 1);
        tick(3'b001, 3'b000);
        tick(3'b001, 3'b000);
        long_conv_i = 1'b0;
        tick(3'b000, 3'b000);
        chk(cnt_of(0) == 2, "R10 mode change keeps count", cnt_of(0), 2);
        tick(3'b001, 3'b000);
        chk(pulse_o == 3'b001, "R10 short period fires", int'(pulse_o), 1);

        // R11: mid-run reset
        tick(3'b111, 3'b000);
        do_reset();
        chk(count_o == 0 && flag_o == 0 && pulse_o == 0, "R11 mid-run reset", int'(count_o), 0);

        finish_run();
    end
endmodule